// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a host and an asynchronous 64K x 16 dynamic memory with extended-data-out page mode. It takes single-word read and write requests over a request/acknowledge port and produces the strobe sequences the memory needs. The 16-bit word address goes out in two halves over an 8-bit address bus: the row half is presented while the row strobe falls, and the column half while the column strobe falls. Writes can target the whole word or a single byte, using separate upper and lower write strobes. Every write is an early write, so the memory never drives its data pins during a write.

After an access the row is left open. A later request to the same row is served by toggling only the column strobe (page mode), which saves the full row cycle. A request to another row, a pending refresh, or the row-open limit closes the row, precharges it and opens a new one. Refresh comes from a separate requester. It is granted only while the row strobe is idle and precharged, and while the grant is held no host access starts. Every timing value is a parameter counted in controller clock cycles.

Top module: `edo_seq`

## Requirements
- R1: After reset, ras_n, cas_n, oe_n, uwe_n and lwe_n are high, and dq_oe, ack, rvalid and rf_gnt are low.
- R2: The row is addr[15:8] and is on ma when ras_n falls. The column is addr[7:0] and is on ma when cas_n falls.
- R3: In a write, be[1]=1 drives uwe_n low and writes dq_out[15:8], and be[0]=1 drives lwe_n low and writes dq_out[7:0]. A byte whose enable is 0 keeps its stored value.
- R4: Each write strobe of a write goes low before cas_n falls and never falls while cas_n is low. oe_n stays high while a write strobe is low, and dq_oe is high only while a write strobe is low.
- R5: A read holds uwe_n and lwe_n high with oe_n low. It samples dq_in on the clock edge CAS_LEN = max(T_CAS, T_CAC) cycles after cas_n falls (2 cycles by default), returns that value on rdata, and pulses rvalid high for one cycle.
- R6: A request that hits the open row is served without a new ras_n fall. This applies while no refresh is pending and the row-open limit is not near.
- R7: A request to a row other than the open one makes ras_n rise, precharge and fall again with the new row.
- R8: ras_n stays high for at least T_RP cycles before every fall, and cas_n is never low while ras_n is high.
- R9: rf_gnt rises only while ras_n and cas_n are high. While it is high, no request is acknowledged and all strobes stay high. When a refresh and a host access are both waiting for an idle row, the refresh is granted first.
- R10: ras_n is never low for more than T_RAS_MAX cycles. An open row with no further hits is closed by the block before that limit.
- R11: ack is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address: row in [15:8], column in [7:0] |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables: [1] upper byte, [0] lower byte |
| ack | output | 1 | One-cycle pulse when the request is taken |
| rdata | output | 16 | Read data |
| rvalid | output | 1 | One-cycle pulse with valid rdata |
| rf_req | input | 1 | Refresh request from the refresh block |
| rf_gnt | output | 1 | Refresh grant; memory strobes idle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| uwe_n | output | 1 | Upper-byte write strobe, active low |
| lwe_n | output | 1 | Lower-byte write strobe, active low |
| ma | output | 8 | Multiplexed memory address |
| dq_in | input | 16 | Data from the memory pins |
| dq_out | output | 16 | Data to the memory pins |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
The assertions assume that the host holds req, wr, addr, wdata and be stable from raising req until it sees ack. They also assume that the refresh requester keeps rf_req high until it has finished with the grant. The bench tasks drive all inputs on the falling clock edge and release req on the edge where ack is seen. rf_req is raised and dropped only around a whole refresh window. The memory model answers a read on the column strobe's fall and holds the data until the next fall, so rdata at the sampling edge comes from the column being read.

// File: rtl/edo_seq_pkg.sv
`timescale 1ns/1ps
package edo_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // row strobe high, precharging
    ST_RASF,   // row address on bus, row strobe falls next
    ST_RCD,    // row-to-column delay
    ST_CSET,   // column address and command set up
    ST_CLOW,   // column strobe low
    ST_CHIGH,  // column precharge, page decision
    ST_REFR    // bus handed to refresh
  } seq_st_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_seq_span.sv
`timescale 1ns/1ps
// Saturating cycle counter with synchronous clear.
module edo_seq_span #(
  parameter int MAXV = 4,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/edo_seq_rowtrk.sv
`timescale 1ns/1ps
// Holds the open row and compares incoming rows against it.
module edo_seq_rowtrk #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [RW-1:0] row_in,
  input  logic [RW-1:0] cmp_row,
  output logic          hit
);
  logic [RW-1:0] open_row;
  logic          open_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_row <= '0;
      open_vld <= 1'b0;
    end else if (load) begin
      open_row <= row_in;
      open_vld <= 1'b1;
    end
  end

  assign hit = open_vld && (open_row == cmp_row);
endmodule

// File: rtl/edo_seq.sv
`timescale 1ns/1ps
module edo_seq
  import edo_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int MAW       = 8,
  parameter int T_RP      = 2,     // row precharge, cycles
  parameter int T_RAS     = 3,     // minimum row strobe low, cycles
  parameter int T_RCD     = 1,     // row address hold before column, cycles
  parameter int T_CAS     = 1,     // minimum column strobe low, cycles
  parameter int T_CAC     = 2,     // column strobe to sampled data, cycles
  parameter int T_CP      = 1,     // column precharge, cycles
  parameter int T_RAS_MAX = 5000   // row-open limit, cycles
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    be,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  input  logic          rf_req,
  output logic          rf_gnt,
  output logic          ras_n,
  output logic          cas_n,
  output logic          oe_n,
  output logic          uwe_n,
  output logic          lwe_n,
  output logic [MAW-1:0] ma,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam int RW          = AW - MAW;
  localparam int CAS_LEN     = imax(T_CAS, T_CAC);
  localparam int TMAX        = imax(imax(T_RCD, CAS_LEN), T_CP);
  localparam int TW          = $clog2(TMAX + 1);
  localparam int LW          = $clog2(T_RAS_MAX + 1);
  localparam int PW          = $clog2(T_RP + 1);
  localparam int PAGE_MARGIN = CAS_LEN + T_CP + 4;

  localparam logic [TW-1:0] RCD_LAST = TW'(T_RCD - 1);
  localparam logic [TW-1:0] CAS_LAST = TW'(CAS_LEN - 1);
  localparam logic [TW-1:0] CP_LAST  = TW'(T_CP - 1);
  localparam logic [LW-1:0] RAS_MINC = LW'(T_RAS - 1);
  localparam logic [LW-1:0] PAGE_CUT = LW'(T_RAS_MAX - PAGE_MARGIN);
  localparam logic [PW-1:0] RP_C     = PW'(T_RP);

  seq_st_t        st;
  logic [TW-1:0]  tcnt;
  logic [LW-1:0]  lo_cnt;
  logic [PW-1:0]  pre_cnt;
  logic           lat_wr;
  logic [1:0]     lat_be;
  logic [MAW-1:0] lat_col;
  logic [DW-1:0]  lat_wd;
  logic           hit;

  // timers shared by all states
  logic pre_ok, ras_ok, page_ok, refr_exit, idle_take, pre_clr;
  assign pre_ok    = (pre_cnt >= RP_C);
  assign ras_ok    = (lo_cnt >= RAS_MINC);
  assign page_ok   = (lo_cnt < PAGE_CUT);
  assign refr_exit = (st == ST_REFR) && !rf_req;
  assign idle_take = (st == ST_IDLE) && pre_ok && !rf_req && req;
  assign pre_clr   = !ras_n || refr_exit;

  edo_seq_span #(.MAXV(T_RAS_MAX)) u_lo (
    .clk(clk), .rst(rst), .clr(ras_n), .cnt(lo_cnt)
  );

  edo_seq_span #(.MAXV(T_RP)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .cnt(pre_cnt)
  );

  edo_seq_rowtrk #(.RW(RW)) u_row (
    .clk(clk), .rst(rst), .load(idle_take),
    .row_in(addr[AW-1:MAW]), .cmp_row(addr[AW-1:MAW]), .hit(hit)
  );

  // column command source: live request on a page hit, latched otherwise
  logic          src_wr;
  logic [1:0]    src_be;
  logic [DW-1:0] src_wd;
  always_comb begin
    if (st == ST_CHIGH) begin
      src_wr = wr;
      src_be = be;
      src_wd = wdata;
    end else begin
      src_wr = lat_wr;
      src_be = lat_be;
      src_wd = lat_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      tcnt    <= '0;
      ack     <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
      rf_gnt  <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      oe_n    <= 1'b1;
      uwe_n   <= 1'b1;
      lwe_n   <= 1'b1;
      ma      <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      lat_wr  <= 1'b0;
      lat_be  <= '0;
      lat_col <= '0;
      lat_wd  <= '0;
    end else begin
      ack    <= 1'b0;
      rvalid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (rf_req && pre_ok) begin
            rf_gnt <= 1'b1;
            st     <= ST_REFR;
          end else if (idle_take) begin
            ack     <= 1'b1;
            lat_wr  <= wr;
            lat_be  <= be;
            lat_col <= addr[MAW-1:0];
            lat_wd  <= wdata;
            ma      <= addr[AW-1:MAW];
            st      <= ST_RASF;
          end
        end
        ST_REFR: begin
          if (!rf_req) begin
            rf_gnt <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        ST_RASF: begin
          ras_n <= 1'b0;
          tcnt  <= '0;
          st    <= ST_RCD;
        end
        ST_RCD: begin
          if (tcnt == RCD_LAST) begin
            ma     <= lat_col;
            oe_n   <= src_wr;
            uwe_n  <= !(src_wr && src_be[1]);
            lwe_n  <= !(src_wr && src_be[0]);
            dq_oe  <= src_wr && (|src_be);
            dq_out <= src_wd;
            st     <= ST_CSET;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_CSET: begin
          cas_n <= 1'b0;
          tcnt  <= '0;
          st    <= ST_CLOW;
        end
        ST_CLOW: begin
          if (tcnt == CAS_LAST) begin
            cas_n <= 1'b1;
            oe_n  <= 1'b1;
            uwe_n <= 1'b1;
            lwe_n <= 1'b1;
            dq_oe <= 1'b0;
            if (!lat_wr) begin
              rdata  <= dq_in;
              rvalid <= 1'b1;
            end
            tcnt <= '0;
            st   <= ST_CHIGH;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_CHIGH: begin
          if (tcnt != CP_LAST) begin
            tcnt <= tcnt + 1'b1;
          end else if (req && hit && page_ok && !rf_req) begin
            ack    <= 1'b1;
            lat_wr <= wr;
            lat_be <= be;
            lat_wd <= wdata;
            ma     <= addr[MAW-1:0];
            oe_n   <= src_wr;
            uwe_n  <= !(src_wr && src_be[1]);
            lwe_n  <= !(src_wr && src_be[0]);
            dq_oe  <= src_wr && (|src_be);
            dq_out <= src_wd;
            st     <= ST_CSET;
          end else if (ras_ok && (req || rf_req || !page_ok)) begin
            ras_n <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_seq_chk.sv
`timescale 1ns/1ps
module edo_seq_chk #(
  parameter int T_RP      = 2,
  parameter int T_RAS_MAX = 5000
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic oe_n,
  input logic uwe_n,
  input logic lwe_n,
  input logic dq_oe,
  input logic ack,
  input logic rvalid,
  input logic rf_gnt
);
  localparam int HW = $clog2(T_RP + 2);
  localparam int LW = $clog2(T_RAS_MAX + 2);
  localparam logic [HW-1:0] HI_TOP = HW'(T_RP + 1);
  localparam logic [HW-1:0] HI_MIN = HW'(T_RP);
  localparam logic [LW-1:0] LO_TOP = LW'(T_RAS_MAX + 1);
  localparam logic [LW-1:0] LO_MAX = LW'(T_RAS_MAX);

  logic [HW-1:0] hi_c;
  logic [LW-1:0] lo_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_c <= '0;
      lo_c <= '0;
    end else if (ras_n) begin
      lo_c <= '0;
      if (hi_c != HI_TOP) hi_c <= hi_c + 1'b1;
    end else begin
      hi_c <= '0;
      if (lo_c != LO_TOP) lo_c <= lo_c + 1'b1;
    end
  end

  // R8
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  // R8
  prech_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_c >= HI_MIN));

  // R10
  ras_limit_chk: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (lo_c <= LO_MAX));

  // R4
  wr_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (!uwe_n || !lwe_n) |-> oe_n);

  // R4
  early_upper_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(uwe_n) |-> cas_n);

  // R4
  early_lower_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lwe_n) |-> cas_n);

  // R4
  dq_drive_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!uwe_n || !lwe_n));

  // R9
  gnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rf_gnt |-> (ras_n && cas_n && !ack));

  // R5
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
endmodule

bind edo_seq edo_seq_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
  .uwe_n(uwe_n), .lwe_n(lwe_n), .dq_oe(dq_oe), .ack(ack),
  .rvalid(rvalid), .rf_gnt(rf_gnt)
);

// File: tb/edo_seq_bench.sv
`timescale 1ns/1ps
module edo_seq_bench;
  localparam int CAS_LEN_EXP = 2;
  localparam int LIMIT       = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, wr = 1'b0, rf_req = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [1:0]  be = '0;
  logic        ack, rvalid, rf_gnt;
  logic [15:0] rdata;
  logic        ras_n, cas_n, oe_n, uwe_n, lwe_n, dq_oe;
  logic [7:0]  ma;
  logic [15:0] dq_in, dq_out;

  always #10 clk = ~clk;

  edo_seq u_edo_seq (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .be(be), .ack(ack), .rdata(rdata), .rvalid(rvalid), .rf_req(rf_req),
    .rf_gnt(rf_gnt), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .uwe_n(uwe_n), .lwe_n(lwe_n), .ma(ma), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [0:65535];
  logic [7:0]  m_row, m_col;
  logic [15:0] dq_q = '0;
  int          ras_falls = 0;
  int          late_wr   = 0;
  int          bad_drive = 0;
  time         cas_fall_t = 0;
  assign dq_in = dq_q;

  always @(negedge ras_n) begin
    m_row = ma;
    ras_falls++;
  end

  always @(negedge cas_n) begin
    m_col      = ma;
    cas_fall_t = $time;
    if (!uwe_n || !lwe_n) begin
      if (!dq_oe || !oe_n) bad_drive++;
      if (!uwe_n) mem[{m_row, m_col}][15:8] = dq_out[15:8];
      if (!lwe_n) mem[{m_row, m_col}][7:0]  = dq_out[7:0];
    end else begin
      dq_q = mem[{m_row, m_col}];
    end
  end

  always @(negedge uwe_n or negedge lwe_n) begin
    if (!cas_n) late_wr++;
  end

  int ras_low_run = 0;
  int ras_low_max = 0;
  always @(posedge clk) begin
    if (!ras_n) begin
      ras_low_run++;
      if (ras_low_run > ras_low_max) ras_low_max = ras_low_run;
    end else ras_low_run = 0;
  end

  // ---------------- host tasks ----------------
  task automatic wait_ack(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ack) begin
        ok = 1'b1;
        req = 1'b0;
        break;
      end
    end
    @(negedge clk);
    check(ack == 1'b0, "R11", "ack single pulse", ack, 0);
  endtask

  task automatic issue(input logic [15:0] a, input logic w,
                       input logic [15:0] d, input logic [1:0] b);
    bit ok;
    @(negedge clk);
    addr = a; wr = w; wdata = d; be = b; req = 1'b1;
    wait_ack(ok);
    check(ok, "R11", "request acknowledged", ok, 1);
  endtask

  task automatic get_rvalid(output logic [15:0] d);
    bit seen = 1'b0;
    d = '0;
    for (int i = 0; i < 50; i++) begin
      if (rvalid) begin
        seen = 1'b1;
        d = rdata;
        check(((($time - 10) - cas_fall_t) / 20) == CAS_LEN_EXP, "R5",
              "sample delay after cas fall",
              int'((($time - 10) - cas_fall_t) / 20), CAS_LEN_EXP);
        @(negedge clk);
        check(rvalid == 1'b0, "R5", "rvalid single pulse", rvalid, 0);
        break;
      end
      @(negedge clk);
    end
    check(seen, "R5", "rvalid seen", seen, 1);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] b);
    issue(a, 1'b1, d, b);
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] a, output logic [15:0] d);
    issue(a, 1'b0, 16'h0, 2'b00);
    get_rvalid(d);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(ras_n && cas_n, "R1", "row/col strobes high", {ras_n, cas_n}, 3);
    check(oe_n && uwe_n && lwe_n, "R1", "oe/we strobes high",
          {oe_n, uwe_n, lwe_n}, 7);
    check(!dq_oe && !ack && !rvalid && !rf_gnt, "R1", "outputs low",
          {dq_oe, ack, rvalid, rf_gnt}, 0);
  endtask

  task automatic t_word();
    logic [15:0] d;
    do_write(16'h2A05, 16'h1234, 2'b11);
    check(m_row == 8'h2A, "R2", "row on ma at ras fall", m_row, 8'h2A);
    check(m_col == 8'h05, "R2", "column on ma at cas fall", m_col, 8'h05);
    check(mem[16'h2A05] == 16'h1234, "R3", "word write stored",
          mem[16'h2A05], 16'h1234);
    do_read(16'h2A05, d);
    check(d == 16'h1234, "R5", "word read data", d, 16'h1234);
    check(late_wr == 0 && bad_drive == 0, "R4", "early write discipline",
          late_wr + bad_drive, 0);
  endtask

  task automatic t_bytes();
    logic [15:0] d;
    int rf0;
    rf0 = ras_falls;
    do_write(16'h3110, 16'hAAAA, 2'b11);
    check(ras_falls - rf0 == 1, "R7", "row miss reopens row",
          ras_falls - rf0, 1);
    do_write(16'h3110, 16'h0055, 2'b01);
    do_read(16'h3110, d);
    check(d == 16'hAA55, "R3", "lower byte only", d, 16'hAA55);
    do_write(16'h3110, 16'h7700, 2'b10);
    do_read(16'h3110, d);
    check(d == 16'h7755, "R3", "upper byte only", d, 16'h7755);
    check(late_wr == 0 && bad_drive == 0, "R4", "byte write discipline",
          late_wr + bad_drive, 0);
  endtask

  task automatic t_page();
    logic [15:0] d;
    int rf0;
    rf0 = ras_falls;
    do_write(16'h3120, 16'hBEEF, 2'b11);
    do_read(16'h3120, d);
    check(d == 16'hBEEF, "R6", "page read data", d, 16'hBEEF);
    do_read(16'h3110, d);
    check(d == 16'h7755, "R6", "page read other column", d, 16'h7755);
    check(ras_falls == rf0, "R6", "no ras fall on page hits",
          ras_falls - rf0, 0);
    check(m_col == 8'h10, "R2", "page column on ma", m_col, 8'h10);
    do_write(16'h4000, 16'hC0DE, 2'b11);
    check(ras_falls - rf0 == 1, "R7", "miss after page opens row",
          ras_falls - rf0, 1);
    check(m_row == 8'h40, "R2", "new row on ma", m_row, 8'h40);
  endtask

  task automatic t_refresh();
    logic [15:0] d;
    bit got_gnt = 1'b0, got_ack = 1'b0, ok;
    @(negedge clk);
    rf_req = 1'b1;
    addr = 16'h3120; wr = 1'b0; be = 2'b00; req = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rf_gnt) got_gnt = 1'b1;
      if (ack) got_ack = 1'b1;
      if (got_gnt || got_ack) break;
    end
    check(got_gnt && !got_ack, "R9", "refresh before host",
          {got_gnt, got_ack}, 2);
    check(ras_n && cas_n, "R9", "strobes idle at grant", {ras_n, cas_n}, 3);
    got_ack = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ack || !ras_n || !cas_n) got_ack = 1'b1;
    end
    check(!got_ack, "R9", "host held off during grant", got_ack, 0);
    rf_req = 1'b0;
    wait_ack(ok);
    check(ok, "R9", "host served after refresh", ok, 1);
    get_rvalid(d);
    check(d == 16'hBEEF, "R9", "read after refresh", d, 16'hBEEF);
  endtask

  task automatic t_limit();
    do_write(16'h5001, 16'h0F0F, 2'b11);
    repeat (20) @(negedge clk);
    check(ras_n == 1'b0, "R6", "row held open while idle", ras_n, 0);
    repeat (LIMIT + 20) @(negedge clk);
    check(ras_n == 1'b1, "R10", "row closed before limit", ras_n, 1);
    check(ras_low_max <= LIMIT, "R10", "longest ras low",
          ras_low_max, LIMIT);
  endtask

  // ---------------- main ----------------
  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word();
    t_bytes();
    t_page();
    t_refresh();
    t_limit();
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule